// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the timing for a raster LCD panel: horizontal sync, vertical sync, data-enable, a divided pixel clock, and pixel/line coordinates. It also gives a one-cycle line-end strobe and a frame-end strobe, plus an alternating bias output for passive panels. Panel timing comes from three packed 32-bit configuration words. The horizontal word gives active width, sync width and porches. The vertical word gives the same fields counted in lines. The control word holds the clock divider, the bias period and the output polarity selects.

A panel-type input selects TFT or passive operation. This choice sets the smallest divider the block will use. The configuration inputs are treated as static. They are captured while the block is disabled and again at each frame boundary, so a change made during a frame takes effect cleanly on the next frame. The divided pixel clock is delivered two ways: as a clock-enable strobe for downstream logic, and as a clock level for the panel pin.

Top module: `lcd_raster_timing`

## Requirements
- R1: The horizontal word holds four fields, each stored as count minus one: active pixels in bits 9:0, sync width in bits 15:10, front porch in bits 23:16, back porch in bits 31:24. A line runs through sync, back porch, active and front porch in that order, one pixel each step. `hsync` is asserted during the sync pixels.
- R2: The vertical word uses the same bit positions. Active lines and sync width are stored minus one, while the front and back porches are raw line counts, so a porch of 0 gives no lines. The lines follow the order sync, back porch, active, front porch, and `vsync` is asserted on the sync lines.
- R3: The pixel divider is bits 7:0 of the control word. It is raised to at least 2 when `tft_mode`=1 and to at least 3 when `tft_mode`=0, and it is at most 255. `pix_ce` pulses for one cycle every divider cycles. Let the phase be the number of cycles since the last pulse, counted from 0. The raw pixel clock level is high when the phase is at least half the divider, rounded down.
- R4: `de` is asserted when both the horizontal and the vertical counters are in their active phases. `pix_x` and `pix_y` then give the zero-based active position, and both are 0 otherwise.
- R5: `line_end` is high for the one `pix_ce` cycle that ends a line's last pixel. `frame_end` is high on the `line_end` of the last line of the frame.
- R6: Control bits 20, 21, 22 and 23 invert `vsync`, `hsync`, `pix_clk` and `de` respectively. Bits 24 and 25 are ignored.
- R7: In passive mode, `ac_bias` starts low and toggles after every N completed lines, where N is control bits 15:8 and 0 counts as 1. In TFT mode it stays low.
- R8: When `enable` is low (and during reset), the counters return to zero. In the following cycle every output is low, regardless of polarity. Counting begins at pixel 0 of line 0 in the cycle after `enable` rises.
- R9: Configuration is captured while the block is disabled and at each `frame_end`. A change during a frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the raster; low forces idle and clears counters |
| tft_mode | input | 1 | 1 = TFT panel, 0 = passive panel |
| cfg_horiz | input | 32 | Horizontal timing word |
| cfg_vert | input | 32 | Vertical timing word |
| cfg_ctrl | input | 32 | Divider, bias period and polarity word |
| pix_ce | output | 1 | Pixel clock-enable strobe |
| pix_clk | output | 1 | Divided pixel clock level, polarity applied |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable, polarity applied |
| pix_x | output | 10 | Active pixel column, 0 outside active |
| pix_y | output | 10 | Active line row, 0 outside active |
| line_end | output | 1 | End-of-line strobe |
| frame_end | output | 1 | End-of-frame strobe |
| ac_bias | output | 1 | Passive-panel bias toggle |

## Verification
Every output is decoded combinationally from registers that change on one clock edge. Each result is therefore due in the cycle that starts at the edge where its divider phase, pixel counter, line counter or bias flip-flop updates. A new pixel appears divider-many cycles after the previous one, counted from the edge where `enable` is first seen high. The bench steps a requirement-level model at each rising edge and compares all outputs at the following falling edge. This keeps the check aligned with the one-edge latency, including the frame where a configuration change is held back until `frame_end`.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int ACT_W   = 10;
    localparam int SYNC_W  = 6;
    localparam int PORCH_W = 8;
    localparam int DIV_W   = 8;
    localparam int ACB_W   = 8;
    localparam int INV_W   = 4;
    localparam int CNT_W   = ACT_W + 2;

    localparam int F_ACT_LSB  = 0;
    localparam int F_SYNC_LSB = 10;
    localparam int F_FP_LSB   = 16;
    localparam int F_BP_LSB   = 24;
    localparam int C_DIV_LSB  = 0;
    localparam int C_ACB_LSB  = 8;
    localparam int C_INV_LSB  = 20;

    localparam logic [DIV_W-1:0] DIV_FLOOR_TFT     = DIV_W'(2);
    localparam logic [DIV_W-1:0] DIV_FLOOR_PASSIVE = DIV_W'(3);

    typedef enum logic [1:0] {
        INV_VSYNC = 2'd0,
        INV_HSYNC = 2'd1,
        INV_PCLK  = 2'd2,
        INV_DE    = 2'd3
    } inv_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] sync_n;
        logic [CNT_W-1:0] back_n;
        logic [CNT_W-1:0] act_n;
        logic [CNT_W-1:0] front_n;
    } axis_cfg_t;

    typedef struct packed {
        axis_cfg_t          h;
        axis_cfg_t          v;
        logic [DIV_W-1:0]   div;
        logic [ACB_W-1:0]   acb_period;
        logic [INV_W-1:0]   inv;
        logic               tft;
    } timing_cfg_t;

    function automatic axis_cfg_t decode_axis(input logic [31:0] w, input logic porch_biased);
        axis_cfg_t a;
        a.sync_n  = CNT_W'(w[F_SYNC_LSB +: SYNC_W]) + CNT_W'(1);
        a.act_n   = CNT_W'(w[F_ACT_LSB +: ACT_W]) + CNT_W'(1);
        a.front_n = CNT_W'(w[F_FP_LSB +: PORCH_W]) + CNT_W'(porch_biased);
        a.back_n  = CNT_W'(w[F_BP_LSB +: PORCH_W]) + CNT_W'(porch_biased);
        return a;
    endfunction

    function automatic timing_cfg_t decode_cfg(input logic [31:0] hw, input logic [31:0] vw,
                                               input logic [31:0] cw, input logic tft);
        timing_cfg_t      c;
        logic [DIV_W-1:0] raw;
        logic [DIV_W-1:0] floor_v;
        c.h          = decode_axis(hw, 1'b1);
        c.v          = decode_axis(vw, 1'b0);
        raw          = cw[C_DIV_LSB +: DIV_W];
        floor_v      = tft ? DIV_FLOOR_TFT : DIV_FLOOR_PASSIVE;
        c.div        = (raw < floor_v) ? floor_v : raw;
        c.acb_period = cw[C_ACB_LSB +: ACB_W];
        c.inv        = cw[C_INV_LSB +: INV_W];
        c.tft        = tft;
        return c;
    endfunction

endpackage

// File: rtl/lcdt_pix_div.sv
module lcdt_pix_div
    import lcdt_pkg::*;
#(
    parameter int W = DIV_W
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick,
    output logic         level
);

    logic [W-1:0] phase_q;

    assign tick  = run && (phase_q == (div - W'(1)));
    assign level = run && (phase_q >= (div >> 1));

    always_ff @(posedge clk) begin
        if (clr) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= tick ? '0 : phase_q + W'(1);
        end
    end

endmodule

// File: rtl/lcdt_axis_ctr.sv
module lcdt_axis_ctr
    import lcdt_pkg::*;
#(
    parameter int OW = ACT_W
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          step,
    input  axis_cfg_t     cfg,
    output logic          wrap,
    output logic          in_sync,
    output logic          in_active,
    output logic [OW-1:0] coord
);

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] act_start;
    logic [CNT_W-1:0] act_stop;
    logic [CNT_W-1:0] last_pos;
    logic             at_last;

    assign act_start = cfg.sync_n + cfg.back_n;
    assign act_stop  = act_start + cfg.act_n;
    assign last_pos  = act_stop + cfg.front_n - CNT_W'(1);
    assign at_last   = (pos_q == last_pos);

    assign wrap      = step && at_last;
    assign in_sync   = (pos_q < cfg.sync_n);
    assign in_active = (pos_q >= act_start) && (pos_q < act_stop);
    assign coord     = in_active ? OW'(pos_q - act_start) : '0;

    always_ff @(posedge clk) begin
        if (clr) begin
            pos_q <= '0;
        end else if (step) begin
            pos_q <= at_last ? '0 : pos_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lcd_raster_timing.sv
module lcd_raster_timing
    import lcdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             tft_mode,
    input  logic [31:0]      cfg_horiz,
    input  logic [31:0]      cfg_vert,
    input  logic [31:0]      cfg_ctrl,
    output logic             pix_ce,
    output logic             pix_clk,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [ACT_W-1:0] pix_x,
    output logic [ACT_W-1:0] pix_y,
    output logic             line_end,
    output logic             frame_end,
    output logic             ac_bias
);

    logic             clr;
    logic             run_q;
    timing_cfg_t      cfg_q;
    logic             tick;
    logic             pclk_lvl;
    logic             h_wrap, h_sync, h_act;
    logic             v_wrap, v_sync, v_act;
    logic [ACT_W-1:0] h_coord, v_coord;
    logic             de_raw;
    logic [INV_W-1:0] raw_sig;
    logic [INV_W-1:0] pol_sig;
    logic [ACB_W-1:0] acb_cnt_q;
    logic [ACB_W-1:0] acb_limit;
    logic             acb_q;

    assign clr = rst || !enable;

    always_ff @(posedge clk) begin
        run_q <= rst ? 1'b0 : enable;
        if (clr || v_wrap) begin
            cfg_q <= decode_cfg(cfg_horiz, cfg_vert, cfg_ctrl, tft_mode);
        end
    end

    lcdt_pix_div #(.W(DIV_W)) u_div (
        .clk   (clk),
        .clr   (clr),
        .run   (run_q),
        .div   (cfg_q.div),
        .tick  (tick),
        .level (pclk_lvl)
    );

    lcdt_axis_ctr #(.OW(ACT_W)) u_hctr (
        .clk       (clk),
        .clr       (clr),
        .step      (tick),
        .cfg       (cfg_q.h),
        .wrap      (h_wrap),
        .in_sync   (h_sync),
        .in_active (h_act),
        .coord     (h_coord)
    );

    lcdt_axis_ctr #(.OW(ACT_W)) u_vctr (
        .clk       (clk),
        .clr       (clr),
        .step      (h_wrap),
        .cfg       (cfg_q.v),
        .wrap      (v_wrap),
        .in_sync   (v_sync),
        .in_active (v_act),
        .coord     (v_coord)
    );

    assign de_raw = h_act && v_act;

    assign raw_sig[INV_VSYNC] = v_sync;
    assign raw_sig[INV_HSYNC] = h_sync;
    assign raw_sig[INV_PCLK]  = pclk_lvl;
    assign raw_sig[INV_DE]    = de_raw;

    for (genvar g = 0; g < INV_W; g++) begin : g_pol
        assign pol_sig[g] = run_q & (raw_sig[g] ^ cfg_q.inv[g]);
    end

    assign vsync   = pol_sig[INV_VSYNC];
    assign hsync   = pol_sig[INV_HSYNC];
    assign pix_clk = pol_sig[INV_PCLK];
    assign de      = pol_sig[INV_DE];

    assign pix_x     = de_raw ? h_coord : '0;
    assign pix_y     = de_raw ? v_coord : '0;
    assign pix_ce    = tick;
    assign line_end  = h_wrap;
    assign frame_end = v_wrap;

    assign acb_limit = (cfg_q.acb_period == '0) ? '0 : cfg_q.acb_period - ACB_W'(1);

    always_ff @(posedge clk) begin
        if (clr) begin
            acb_cnt_q <= '0;
            acb_q     <= 1'b0;
        end else if (h_wrap) begin
            if (acb_cnt_q == acb_limit) begin
                acb_cnt_q <= '0;
                acb_q     <= ~acb_q;
            end else begin
                acb_cnt_q <= acb_cnt_q + ACB_W'(1);
            end
        end
    end

    assign ac_bias = run_q && !cfg_q.tft && acb_q;

endmodule

// File: rtl/lcdt_checker.sv
module lcdt_checker (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       pix_ce,
    input logic       pix_clk,
    input logic       hsync,
    input logic       vsync,
    input logic       de,
    input logic [9:0] pix_x,
    input logic       line_end,
    input logic       frame_end,
    input logic       ac_bias
);

    a_r3_ce_not_back_to_back: assert property (@(posedge clk) disable iff (rst)
        pix_ce |=> !pix_ce);

    a_r5_line_end_on_ce: assert property (@(posedge clk) disable iff (rst)
        line_end |-> pix_ce);

    a_r5_frame_end_on_line_end: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> line_end);

    a_r8_idle_after_disable: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!pix_ce && !pix_clk && !hsync && !vsync && !de && !line_end && !ac_bias));

    a_r4_x_zero_after_line_end: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (pix_x == 10'd0));

    a_r7_bias_moves_on_line_end: assert property (@(posedge clk) disable iff (rst)
        (enable && !line_end) |=> $stable(ac_bias));

endmodule

bind lcd_raster_timing lcdt_checker u_lcdt_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .pix_ce    (pix_ce),
    .pix_clk   (pix_clk),
    .hsync     (hsync),
    .vsync     (vsync),
    .de        (de),
    .pix_x     (pix_x),
    .line_end  (line_end),
    .frame_end (frame_end),
    .ac_bias   (ac_bias)
);

// File: tb/lcd_raster_timing_tb_top.sv
module lcd_raster_timing_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        tft_mode = 1'b0;
    logic [31:0] cfg_horiz = '0;
    logic [31:0] cfg_vert = '0;
    logic [31:0] cfg_ctrl = '0;
    logic        pix_ce, pix_clk, hsync, vsync, de, line_end, frame_end, ac_bias;
    logic [9:0]  pix_x, pix_y;

    always #2 clk = ~clk;

    lcd_raster_timing dut_i (
        .clk(clk), .rst(rst), .enable(enable), .tft_mode(tft_mode),
        .cfg_horiz(cfg_horiz), .cfg_vert(cfg_vert), .cfg_ctrl(cfg_ctrl),
        .pix_ce(pix_ce), .pix_clk(pix_clk), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .pix_y(pix_y), .line_end(line_end), .frame_end(frame_end),
        .ac_bias(ac_bias)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string scen  = "R8";

    // reference state, built from the requirements
    int m_run, m_d, m_h, m_v, m_acn, m_ac;
    int mhs, mhb, mha, mhf, mvs, mvb, mva, mvf, mdiv, macb, mtft;
    int inv_v, inv_h, inv_p, inv_de;

    function automatic logic [31:0] axis_word(int act, int sw, int fp, int bp);
        return {bp[7:0], fp[7:0], sw[5:0], act[9:0]};
    endfunction

    function automatic logic [31:0] ctrl_word(int dv, int acb, int pol);
        return {6'd0, pol[5:0], 4'd0, acb[7:0], dv[7:0]};
    endfunction

    function automatic int htot();
        return mhs + mhb + mha + mhf;
    endfunction

    function automatic int vtot();
        return mvs + mvb + mva + mvf;
    endfunction

    function automatic int frame_cycles();
        return htot() * vtot() * mdiv;
    endfunction

    task automatic m_latch();
        int raw, fl;
        mhs = int'(cfg_horiz[15:10]) + 1;   // R1: minus-one fields
        mhb = int'(cfg_horiz[31:24]) + 1;
        mha = int'(cfg_horiz[9:0]) + 1;
        mhf = int'(cfg_horiz[23:16]) + 1;
        mvs = int'(cfg_vert[15:10]) + 1;    // R2: porches raw
        mvb = int'(cfg_vert[31:24]);
        mva = int'(cfg_vert[9:0]) + 1;
        mvf = int'(cfg_vert[23:16]);
        raw = int'(cfg_ctrl[7:0]);
        fl  = tft_mode ? 2 : 3;
        mdiv = (raw < fl) ? fl : raw;
        macb = int'(cfg_ctrl[15:8]);
        inv_v  = int'(cfg_ctrl[20]);
        inv_h  = int'(cfg_ctrl[21]);
        inv_p  = int'(cfg_ctrl[22]);
        inv_de = int'(cfg_ctrl[23]);
        mtft   = int'(tft_mode);
    endtask

    task automatic m_step();
        int tick, le, fe, lim;
        tick = (m_run != 0) && (m_d == mdiv - 1);
        le   = tick && (m_h == htot() - 1);
        fe   = le && (m_v == vtot() - 1);
        if (rst || !enable) begin
            m_d = 0; m_h = 0; m_v = 0; m_acn = 0; m_ac = 0;
            m_latch();
        end else begin
            if (m_run != 0) m_d = tick ? 0 : m_d + 1;
            if (tick) m_h = le ? 0 : m_h + 1;
            if (le) begin
                m_v = fe ? 0 : m_v + 1;
                lim = (macb == 0) ? 0 : macb - 1;
                if (m_acn == lim) begin
                    m_acn = 0;
                    m_ac  = 1 - m_ac;
                end else begin
                    m_acn = m_acn + 1;
                end
            end
            if (fe) m_latch();
        end
        m_run = rst ? 0 : int'(enable);
    endtask

    task automatic check(string req, string nm, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (scenario %s) %s: actual %0d expected %0d at %0t",
                     req, scen, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int tick, le, fe, hact, vact, de_raw, ex, ey;
        tick = (m_run != 0) && (m_d == mdiv - 1);
        le   = tick && (m_h == htot() - 1);
        fe   = le && (m_v == vtot() - 1);
        hact = (m_h >= mhs + mhb) && (m_h < mhs + mhb + mha);
        vact = (m_v >= mvs + mvb) && (m_v < mvs + mvb + mva);
        de_raw = hact && vact;
        ex = de_raw ? m_h - (mhs + mhb) : 0;
        ey = de_raw ? m_v - (mvs + mvb) : 0;
        check("R3", "pix_ce", int'(pix_ce), tick);
        check("R3", "pix_clk", int'(pix_clk), m_run & (int'(m_d >= mdiv / 2) ^ inv_p));
        check("R1", "hsync", int'(hsync), m_run & (int'(m_h < mhs) ^ inv_h));
        check("R2", "vsync", int'(vsync), m_run & (int'(m_v < mvs) ^ inv_v));
        check("R4", "de", int'(de), m_run & (de_raw ^ inv_de));
        check("R4", "pix_x", int'(pix_x), ex);
        check("R4", "pix_y", int'(pix_y), ey);
        check("R5", "line_end", int'(line_end), le);
        check("R5", "frame_end", int'(frame_end), fe);
        check("R7", "ac_bias", int'(ac_bias), m_run & (1 - mtft) & m_ac);
    endtask

    task automatic cycles(int n);
        repeat (n) begin
            @(posedge clk);
            m_step();
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic configure(logic [31:0] hw, logic [31:0] vw, logic [31:0] cw, logic t);
        enable    = 1'b0;
        cfg_horiz = hw;
        cfg_vert  = vw;
        cfg_ctrl  = cw;
        tft_mode  = t;
        cycles(2);
        enable = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_run = 0; m_d = 0; m_h = 0; m_v = 0; m_acn = 0; m_ac = 0;
        m_latch();

        // R8: reset state, all outputs low
        scen = "R8";
        cycles(3);
        rst = 1'b0;
        cycles(2);

        // R1: horizontal order and minus-one fields, TFT, divider floor 2
        scen = "R1";
        configure(axis_word(7, 1, 0, 2), axis_word(3, 0, 1, 2), ctrl_word(0, 0, 0), 1'b1);
        cycles(2 * frame_cycles() + 5);

        // R2: zero vertical porches, passive divider floor 3, bias every 2 lines
        scen = "R2";
        configure(axis_word(5, 0, 1, 0), axis_word(2, 1, 0, 0), ctrl_word(1, 2, 0), 1'b0);
        cycles(2 * frame_cycles() + 5);

        // R6: all polarity bits plus reserved bits 24 and 25 set
        scen = "R6";
        configure(axis_word(4, 2, 1, 1), axis_word(2, 0, 1, 1), ctrl_word(4, 0, 6'h3F), 1'b0);
        cycles(2 * frame_cycles() + 5);

        // R3: largest divider on a tiny frame
        scen = "R3";
        configure(axis_word(0, 0, 0, 0), axis_word(0, 0, 0, 0), ctrl_word(255, 0, 0), 1'b1);
        cycles(2 * frame_cycles() + 5);

        // R7: passive bias period 3, TFT bias stays low
        scen = "R7";
        configure(axis_word(3, 0, 0, 0), axis_word(4, 0, 1, 1), ctrl_word(3, 3, 0), 1'b0);
        cycles(3 * frame_cycles());
        configure(axis_word(3, 0, 0, 0), axis_word(4, 0, 1, 1), ctrl_word(3, 1, 0), 1'b1);
        cycles(2 * frame_cycles());

        // R9: configuration changed mid-frame waits for the frame boundary
        scen = "R9";
        configure(axis_word(6, 1, 1, 1), axis_word(3, 1, 1, 1), ctrl_word(2, 0, 0), 1'b1);
        cycles(frame_cycles() / 2);
        cfg_horiz = axis_word(9, 0, 2, 0);
        cfg_ctrl  = ctrl_word(5, 0, 6'h0C);
        cycles(frame_cycles());
        cycles(2 * frame_cycles());

        // R8: drop enable in the middle of a frame, then restart from pixel 0
        scen = "R8";
        cycles(frame_cycles() / 3);
        enable = 1'b0;
        cycles(4);
        enable = 1'b1;
        cycles(frame_cycles() + 3);

        // mixed random configurations
        for (int i = 0; i < 10; i++) begin
            scen = "RND";
            configure(axis_word($urandom % 12, $urandom % 4, $urandom % 4, $urandom % 4),
                      axis_word($urandom % 6, $urandom % 3, $urandom % 3, $urandom % 3),
                      ctrl_word($urandom % 7, $urandom % 5, $urandom % 64),
                      logic'($urandom % 2));
            cycles(frame_cycles() * 3 / 2 + 2);
        end

        enable = 1'b0;
        cycles(3);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule